// File: doc/BRIEF.md
# Strand Status and Sleep Register

This block holds the status word of one hardware strand in a core whose strands come in aligned groups of four. Software writes the word to say whether the strand should keep running. Writing the active bit as zero asks the scheduler to put the strand to sleep, and the block signals this with a one-cycle request pulse. A write that tries to turn on speculation is illegal. It is reported and changes nothing.

A read returns a word that is assembled live every cycle. It holds the stored active bit and the speculative bit, the strand's own identifier, and one 2-bit state field for each of the four strands in the strand's group. The group is the four strands whose identifiers differ only in their two low bits. The thread scheduler supplies the raw state of each group member. The block turns each raw state into a run, idle or halt code. A raw value it does not recognise raises an error flag.

Top module: `strand_status_reg`

## Requirements
- R1: After reset the active bit (read bit 0) is 1, and `sleep_req` and `wr_err` are 0.
- R2: A legal write (write bit 2 clear) stores write bit 0 as the active bit. Every other written bit is ignored, and read bit 1 (speculative) always reads 0.
- R3: A write with bit 2 (speculation enable) set is illegal. `wr_err` is high for exactly the cycle after the write edge, the active bit keeps its old value, and no sleep request is made.
- R4: A legal write with bit 0 clear raises `sleep_req` for exactly the cycle after the write edge. A legal write with bit 0 set raises no request.
- R5: Read bits 15..8 carry `strand_id`. Read bits 7..2 and 31..24 read as 0.
- R6: Group member k is the strand whose identifier's low two bits equal k. Its state input is `member_state[2k+1:2k]` and its read field sits at bits (23-2k)..(22-2k). Member 0 therefore has the highest field, at bits 23..22.
- R7: Raw state 2'b00 (active) reads as run 2'b01, 2'b01 (suspended) reads as idle 2'b10, and 2'b10 (halted) reads as halt 2'b11.
- R8: Raw state 2'b11 is invalid. Its field reads 2'b00 and `state_err` is 1 in the same cycle. With no invalid member, `state_err` is 0.
- R9: `rd_data` and `state_err` follow `strand_id` and `member_state` combinationally, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | DATA_W | Write value: bit 0 is active, bit 2 is speculation enable |
| strand_id | input | ID_W | Identifier of this strand |
| member_state | input | 8 | Raw states of the four group members, 2 bits each, member k at [2k+1:2k] |
| rd_data | output | DATA_W | Composed status word |
| sleep_req | output | 1 | One-cycle request to suspend the strand |
| wr_err | output | 1 | One-cycle flag for an illegal write |
| state_err | output | 1 | Some member's raw state is invalid |

## Verification
The hardest case to reach from the ports is an illegal write that arrives while the strand is already asleep. The write also carries bit 0 clear, so a wrong design would either report a second sleep request or drop the error. The bench reaches this by first driving the active bit to each of its two values with a legal write. From each starting value it then sweeps every combination of the low four write bits, with the upper bits both clear and set. The read side is swept over all 256 combinations of the four raw member states, for several identifiers, including ones whose low bits are nonzero.

// File: rtl/strand_sts_pkg.sv
// Shared layout constants and encodings for the strand status register.
// Assumes a 32-bit status word, an 8-bit strand identifier and groups of four.
package strand_sts_pkg;
    localparam int STS_DATA_W    = 32;
    localparam int STS_ID_W      = 8;
    localparam int GROUP_N       = 4;
    localparam int ST_W          = 2;
    localparam int BIT_ACTIVE    = 0;
    localparam int BIT_SPEC      = 1;
    localparam int BIT_SPEC_EN   = 2;
    localparam int ID_LSB        = 8;
    localparam int FIELD0_LSB    = 22;
    localparam int FIELD_STRIDE  = 2;

    // Raw strand states as supplied by the scheduler.
    typedef enum logic [ST_W-1:0] {
        RAW_ACTIVE = 2'b00,
        RAW_SUSP   = 2'b01,
        RAW_HALTED = 2'b10,
        RAW_BAD    = 2'b11
    } raw_state_e;

    // Codes presented in the read word.
    typedef enum logic [ST_W-1:0] {
        FLD_NONE = 2'b00,
        FLD_RUN  = 2'b01,
        FLD_IDLE = 2'b10,
        FLD_HALT = 2'b11
    } fld_code_e;
endpackage

// File: rtl/strand_state_enc.sv
// Maps one member's raw scheduler state to its read-field code.
// Purely combinational. An unknown raw value yields FLD_NONE and sets bad.
module strand_state_enc
    import strand_sts_pkg::*;
(
    input  logic [ST_W-1:0] raw,
    output logic [ST_W-1:0] code,
    output logic            bad
);
    // Translate the raw state into the field encoding.
    always_comb begin
        bad  = 1'b0;
        case (raw)
            RAW_ACTIVE: code = FLD_RUN;
            RAW_SUSP:   code = FLD_IDLE;
            RAW_HALTED: code = FLD_HALT;
            default: begin
                code = FLD_NONE;
                bad  = 1'b1;
            end
        endcase
    end

    // R8: the empty code appears only together with the error flag.
    always_comb begin
        assert_code_flag_R8: assert ((code == FLD_NONE) == bad)
            else $error("encoder code/flag mismatch");
    end
endmodule

// File: rtl/strand_sts_ctrl.sv
// Holds the active bit and issues the sleep and illegal-write pulses.
// Assumes that a write is a single-cycle strobe. The outputs are registered
// and are high in the cycle after the write edge.
module strand_sts_ctrl
    import strand_sts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_active,
    input  logic wr_spec_en,
    output logic active,
    output logic sleep_req,
    output logic wr_err
);
    logic legal_wr;
    logic illegal_wr;

    // Split a write into the legal and the rejected case.
    always_comb begin
        legal_wr   = wr_en && !wr_spec_en;
        illegal_wr = wr_en &&  wr_spec_en;
    end

    // Store the active bit and form the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b1;
            sleep_req <= 1'b0;
            wr_err    <= 1'b0;
        end else begin
            if (legal_wr) active <= wr_active;
            sleep_req <= legal_wr && !wr_active;
            wr_err    <= illegal_wr;
        end
    end

    // R3: a rejected write leaves the active bit untouched.
    assert_illegal_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_spec_en) |=> $stable(active));

    // R3/R4: a rejected write never asks for sleep.
    assert_err_no_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_req && wr_err));

    // R4: a sleep request always leaves the strand inactive.
    assert_sleep_inactive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> !active);

    // R4: a request without a write does not outlive one cycle.
    assert_sleep_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !wr_en) |=> !sleep_req);

    // R2: a legal write lands in the active bit.
    assert_store_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_spec_en) |=> (active == $past(wr_active)));
endmodule

// File: rtl/strand_sts_compose.sv
// Assembles the read word from the stored bits, the identifier and the
// member codes. Member k's field sits FIELD_STRIDE*k bits below field 0.
module strand_sts_compose
    import strand_sts_pkg::*;
#(
    parameter int DATA_W = STS_DATA_W,
    parameter int ID_W   = STS_ID_W
) (
    input  logic                            active,
    input  logic                            spec,
    input  logic [ID_W-1:0]                 strand_id,
    input  logic [GROUP_N-1:0][ST_W-1:0]    codes,
    output logic [DATA_W-1:0]               word
);
    // Place every item at its fixed position in the word.
    always_comb begin
        word               = '0;
        word[BIT_ACTIVE]   = active;
        word[BIT_SPEC]     = spec;
        word[ID_LSB +: ID_W] = strand_id;
        for (int k = 0; k < GROUP_N; k++) begin
            word[FIELD0_LSB - k*FIELD_STRIDE +: ST_W] = codes[k];
        end
    end
endmodule

// File: rtl/strand_status_reg.sv
// Top of the strand status register. It stores the active bit, issues the
// sleep and error pulses, and composes the live read word from the states of
// the four strands in the aligned group.
// Assumes that member_state[2k+1:2k] comes from the group member whose
// identifier has low bits k.
module strand_status_reg
    import strand_sts_pkg::*;
#(
    parameter int DATA_W = STS_DATA_W,
    parameter int ID_W   = STS_ID_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ID_W-1:0]          strand_id,
    input  logic [GROUP_N*ST_W-1:0]  member_state,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     sleep_req,
    output logic                     wr_err,
    output logic                     state_err
);
    localparam int FIELD_TOP = FIELD0_LSB + ST_W - 1;

    logic                         active;
    logic [GROUP_N-1:0][ST_W-1:0] codes;
    logic [GROUP_N-1:0]           bad;

    strand_sts_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_active  (wr_data[BIT_ACTIVE]),
        .wr_spec_en (wr_data[BIT_SPEC_EN]),
        .active     (active),
        .sleep_req  (sleep_req),
        .wr_err     (wr_err)
    );

    for (genvar k = 0; k < GROUP_N; k++) begin : g_member
        strand_state_enc u_enc (
            .raw  (member_state[k*ST_W +: ST_W]),
            .code (codes[k]),
            .bad  (bad[k])
        );
    end

    // Flag any member whose raw state is not recognised.
    always_comb state_err = |bad;

    strand_sts_compose #(.DATA_W(DATA_W), .ID_W(ID_W)) u_compose (
        .active    (active),
        .spec      (1'b0),
        .strand_id (strand_id),
        .codes     (codes),
        .word      (rd_data)
    );

    // R8: an error implies at least one empty field in the read word.
    assert_err_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_err |-> ((rd_data[FIELD_TOP -: ST_W] == 2'b00) ||
                       (rd_data[FIELD_TOP-2 -: ST_W] == 2'b00) ||
                       (rd_data[FIELD_TOP-4 -: ST_W] == 2'b00) ||
                       (rd_data[FIELD_TOP-6 -: ST_W] == 2'b00)));

    // R5: bits above the fields stay zero.
    assert_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:FIELD_TOP+1] == '0);
endmodule

// File: tb/strand_status_reg_test.sv
// Sweep bench for strand_status_reg. The expected values are computed here
// from the requirements.
module strand_status_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  strand_id = '0;
    logic [7:0]  member_state = '0;
    logic [31:0] rd_data;
    logic        sleep_req, wr_err, state_err;

    int checks = 0;
    int fails  = 0;
    logic exp_active;

    strand_status_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .strand_id(strand_id), .member_state(member_state),
        .rd_data(rd_data), .sleep_req(sleep_req), .wr_err(wr_err),
        .state_err(state_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic act, input logic [7:0] id,
                                             input logic [7:0] ms);
        logic [31:0] w;
        w = {24'd0, 7'd0, act} | ({24'd0, id} << 8);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] raw;
            logic [1:0] c;
            raw = ms[2*k +: 2];
            c = (raw == 2'b11) ? 2'b00 : raw + 2'b01;
            w = w | ({30'd0, c} << (22 - 2*k));
        end
        return w;
    endfunction

    // One write, then check the pulses, the stored bit and that the pulses end.
    task automatic do_write(input logic [31:0] d);
        logic ill;
        ill = d[2];
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (!ill) exp_active = d[0];
        check("R3 wr_err", {31'd0, wr_err}, {31'd0, ill});
        check("R4 sleep_req", {31'd0, sleep_req}, {31'd0, !ill && !d[0]});
        check("R2 active/spec bits", {30'd0, rd_data[1:0]}, {30'd0, 1'b0, exp_active});
        @(posedge clk); #1;
        check("R4 sleep pulse ends", {31'd0, sleep_req}, 32'd0);
        check("R3 err pulse ends", {31'd0, wr_err}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        exp_active = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 active", {31'd0, rd_data[0]}, 32'd1);
        check("R1 sleep_req", {31'd0, sleep_req}, 32'd0);
        check("R1 wr_err", {31'd0, wr_err}, 32'd0);

        // R2 R3 R4 write sweep from both starting states, upper bits clear and set
        for (int start = 0; start < 2; start++) begin
            for (int hi = 0; hi < 2; hi++) begin
                for (int v = 0; v < 16; v++) begin
                    do_write({31'd0, start[0]});
                    do_write((hi != 0 ? 32'hFFFF_FFF0 : 32'h0) | v);
                end
            end
        end

        // R5 R6 R7 R8 R9 read sweep over every member-state combination
        for (int a = 0; a < 2; a++) begin
            do_write({31'd0, a[0]});
            for (int i = 0; i < 5; i++) begin
                logic [7:0] id;
                case (i)
                    0: id = 8'h00;
                    1: id = 8'h05;
                    2: id = 8'h7E;
                    3: id = 8'hFF;
                    default: id = 8'hA3;
                endcase
                for (int ms = 0; ms < 256; ms++) begin
                    logic bad;
                    strand_id = id;
                    member_state = ms[7:0];
                    #1;
                    bad = (ms[1:0] == 2'b11) || (ms[3:2] == 2'b11) ||
                          (ms[5:4] == 2'b11) || (ms[7:6] == 2'b11);
                    check("R5/R6/R7/R9 rd_data", rd_data, exp_word(exp_active, id, ms[7:0]));
                    check("R8 state_err", {31'd0, state_err}, {31'd0, bad});
                end
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule